// File: doc/BRIEF.md
# In-DRAM Row Copy Sequencer

This block sits on the memory-controller side and copies one whole row (one 4 KB page) from a source row to a destination row without moving any data over the DRAM data bus. It first activates the source row so that the sense amplifiers latch its contents. It then sends a dedicated deactivate command, which closes the source wordline but leaves the sense amplifiers holding their data. After a short gap it activates the destination row, and the still-driven sense amplifiers write the latched page into that row. A normal precharge ends the sequence, and the block reports completion.

The in-array trick only works when both rows share the same sense amplifiers, which means the same bank and the same subarray. For any other pair the block sends no DRAM commands. It hands the request to a conventional read/write engine through a fallback request and waits for that engine to finish. A copy whose source equals its destination finishes at once. If the target bank already has a row open when the request is accepted, that row is precharged first. While a copy is in progress, new requests are ignored.

Top module: `rowCopySeq`

## Requirements
- R1: After reset `busy`, `cmdValid`, `done` and `fbValid` are all low.
- R2: A row address is {bank, subarray, local row}, with the bank in the top BANK_W bits and the subarray in the next SUB_W bits. The fast path is taken only when both bank and subarray are equal. `cmdBank` carries the bank and `cmdRow` carries {subarray, local row}.
- R3: `cmdOp` encoding is 0 none, 1 activate, 2 precharge, 3 deactivate-keep-sense-amps. A fast copy issues, in order: activate source, deactivate, activate destination, precharge. All of these go to the request's bank, and each command is valid for one cycle. With no row open, the first command appears in the cycle after the request is accepted.
- R4: If `openMask` has the target bank's bit set in the accept cycle, a precharge is issued in the cycle after acceptance and the source activate follows T_RP cycles later.
- R5: The deactivate follows the source activate by exactly T_RAS cycles, and the final precharge follows the destination activate by exactly T_RAS cycles.
- R6: The destination activate follows the deactivate by exactly T_GAP cycles.
- R7: `done` is a one-cycle pulse T_RP cycles after the final precharge, and `busy` is low in the following cycle.
- R8: If the bank or subarray differs, `fbValid` is raised in the cycle after acceptance with `fbSrc`/`fbDst` equal to the request, and no DRAM command is issued. `fbValid` stays high until `fbDone`, and `done` is raised in the cycle in which `fbDone` is seen.
- R9: A request presented while `busy` is high is ignored. The running sequence keeps its addresses and timing, and the ignored request produces no commands, fallback or `done`.
- R10: A request with source equal to destination raises `done` in the cycle after acceptance and issues no command and no fallback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Copy request strobe, accepted when not busy |
| reqSrc | input | BANK_W+SUB_W+LOC_W | Source row address |
| reqDst | input | BANK_W+SUB_W+LOC_W | Destination row address |
| openMask | input | 2**BANK_W | Per-bank row-open indication from the controller |
| fbDone | input | 1 | Fallback copy engine finished |
| busy | output | 1 | Copy in progress |
| cmdValid | output | 1 | DRAM command valid this cycle |
| cmdOp | output | 2 | DRAM command code |
| cmdBank | output | BANK_W | Command bank |
| cmdRow | output | SUB_W+LOC_W | Command row within bank |
| done | output | 1 | Copy complete pulse |
| fbValid | output | 1 | Fallback copy request |
| fbSrc | output | BANK_W+SUB_W+LOC_W | Fallback source row |
| fbDst | output | BANK_W+SUB_W+LOC_W | Fallback destination row |

## Verification
If the sequencer leaves its step order, the very next command cycle shows a wrong opcode or a wrong row at the command port. If a timing counter is reloaded with the wrong value, a command appears one or more cycles early or late, so the cycle-by-cycle comparison catches it inside a single copy. If the address latch is corrupted, for example by a request arriving while busy, the rows on `cmdRow` or on the fallback outputs differ from the original request. If the classification logic is wrong, the block sends commands where a fallback was due, or the reverse, in the first cycle after acceptance.

// File: rtl/rowcopy_pkg.sv
package rowcopy_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ACT   = 2'd1,
    OP_PRE   = 2'd2,
    OP_DEACT = 2'd3
  } dramOp_e;

  typedef enum logic [1:0] {
    TSEL_RP  = 2'd0,
    TSEL_RAS = 2'd1,
    TSEL_GAP = 2'd2
  } tSel_e;

  typedef struct packed {
    logic    latch;
    logic    cntLoad;
    tSel_e   tSel;
    dramOp_e op;
    logic    useDst;
  } ctrlStrobe_t;
endpackage

// File: rtl/rcDatapath.sv
module rcDatapath
  import rowcopy_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int SUB_W  = 4,
  parameter int LOC_W  = 5,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3,
  parameter int T_GAP  = 2,
  localparam int ROW_W = BANK_W + SUB_W + LOC_W,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ROW_W-1:0]        reqSrc,
  input  logic [ROW_W-1:0]        reqDst,
  input  logic [NBANK-1:0]        openMask,
  input  ctrlStrobe_t             strobe,
  output logic                    reqSame,
  output logic                    reqFast,
  output logic                    reqOpen,
  output logic                    cntZero,
  output logic                    cmdValid,
  output logic [1:0]              cmdOp,
  output logic [BANK_W-1:0]       cmdBank,
  output logic [SUB_W+LOC_W-1:0]  cmdRow,
  output logic [ROW_W-1:0]        fbSrc,
  output logic [ROW_W-1:0]        fbDst
);
  localparam int TMAX0 = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int TMAX  = (TMAX0 > T_GAP) ? TMAX0 : T_GAP;
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int HI_W  = BANK_W + SUB_W;

  logic [ROW_W-1:0] srcQ, dstQ;
  logic [CNT_W-1:0] cnt, loadVal;

  // request classification, looked at only in the accept cycle
  assign reqSame = (reqSrc == reqDst);
  assign reqFast = (reqSrc[ROW_W-1 -: HI_W] == reqDst[ROW_W-1 -: HI_W]);
  assign reqOpen = openMask[reqSrc[ROW_W-1 -: BANK_W]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ <= '0;
      dstQ <= '0;
    end else if (strobe.latch) begin
      srcQ <= reqSrc;
      dstQ <= reqDst;
    end
  end

  always_comb begin
    case (strobe.tSel)
      TSEL_RAS: loadVal = CNT_W'(T_RAS - 1);
      TSEL_GAP: loadVal = CNT_W'(T_GAP - 1);
      default:  loadVal = CNT_W'(T_RP - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.cntLoad)  cnt <= loadVal;
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end
  assign cntZero = (cnt == '0);

  assign cmdValid = (strobe.op != OP_NONE);
  assign cmdOp    = strobe.op;
  assign cmdBank  = srcQ[ROW_W-1 -: BANK_W];
  assign cmdRow   = strobe.useDst ? dstQ[SUB_W+LOC_W-1:0] : srcQ[SUB_W+LOC_W-1:0];
  assign fbSrc    = srcQ;
  assign fbDst    = dstQ;
endmodule

// File: rtl/rcControl.sv
module rcControl
  import rowcopy_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqSame,
  input  logic        reqFast,
  input  logic        reqOpen,
  input  logic        cntZero,
  input  logic        fbDone,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        fbValid
);
  typedef enum logic [3:0] {
    S_IDLE, S_PRE0, S_ACTS, S_DEACT, S_ACTD, S_PRE1, S_FIN, S_SAME, S_FB
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '{latch: 1'b0, cntLoad: 1'b0, tSel: TSEL_RP, op: OP_NONE, useDst: 1'b0};
    nextState = state;
    done      = 1'b0;
    fbValid   = 1'b0;
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.latch = 1'b1;
        if (reqSame)      nextState = S_SAME;
        else if (reqFast) nextState = reqOpen ? S_PRE0 : S_ACTS;
        else              nextState = S_FB;
      end
      S_PRE0: if (cntZero) begin
        strobe.op = OP_PRE; strobe.cntLoad = 1'b1; strobe.tSel = TSEL_RP;
        nextState = S_ACTS;
      end
      S_ACTS: if (cntZero) begin
        strobe.op = OP_ACT; strobe.cntLoad = 1'b1; strobe.tSel = TSEL_RAS;
        nextState = S_DEACT;
      end
      S_DEACT: if (cntZero) begin
        strobe.op = OP_DEACT; strobe.cntLoad = 1'b1; strobe.tSel = TSEL_GAP;
        nextState = S_ACTD;
      end
      S_ACTD: if (cntZero) begin
        strobe.op = OP_ACT; strobe.useDst = 1'b1;
        strobe.cntLoad = 1'b1; strobe.tSel = TSEL_RAS;
        nextState = S_PRE1;
      end
      S_PRE1: if (cntZero) begin
        strobe.op = OP_PRE; strobe.useDst = 1'b1;
        strobe.cntLoad = 1'b1; strobe.tSel = TSEL_RP;
        nextState = S_FIN;
      end
      S_FIN: if (cntZero) begin
        done = 1'b1; nextState = S_IDLE;
      end
      S_SAME: begin
        done = 1'b1; nextState = S_IDLE;
      end
      S_FB: begin
        fbValid = 1'b1;
        if (fbDone) begin
          done = 1'b1; nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/rowCopySeq.sv
module rowCopySeq
  import rowcopy_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int SUB_W  = 4,
  parameter int LOC_W  = 5,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3,
  parameter int T_GAP  = 2,
  localparam int ROW_W = BANK_W + SUB_W + LOC_W,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [ROW_W-1:0]       reqSrc,
  input  logic [ROW_W-1:0]       reqDst,
  input  logic [NBANK-1:0]       openMask,
  input  logic                   fbDone,
  output logic                   busy,
  output logic                   cmdValid,
  output logic [1:0]             cmdOp,
  output logic [BANK_W-1:0]      cmdBank,
  output logic [SUB_W+LOC_W-1:0] cmdRow,
  output logic                   done,
  output logic                   fbValid,
  output logic [ROW_W-1:0]       fbSrc,
  output logic [ROW_W-1:0]       fbDst
);
  ctrlStrobe_t strobe;
  logic reqSame, reqFast, reqOpen, cntZero;

  rcControl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSame(reqSame),
    .reqFast(reqFast), .reqOpen(reqOpen), .cntZero(cntZero), .fbDone(fbDone),
    .strobe(strobe), .busy(busy), .done(done), .fbValid(fbValid)
  );

  rcDatapath #(
    .BANK_W(BANK_W), .SUB_W(SUB_W), .LOC_W(LOC_W),
    .T_RAS(T_RAS), .T_RP(T_RP), .T_GAP(T_GAP)
  ) uData (
    .clk(clk), .rstN(rstN), .reqSrc(reqSrc), .reqDst(reqDst),
    .openMask(openMask), .strobe(strobe), .reqSame(reqSame),
    .reqFast(reqFast), .reqOpen(reqOpen), .cntZero(cntZero),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdRow(cmdRow),
    .fbSrc(fbSrc), .fbDst(fbDst)
  );
endmodule

// File: rtl/rowCopySeq_chk.sv
module rowCopySeq_chk #(
  parameter int BANK_W = 3,
  parameter int SUB_W  = 4,
  parameter int LOC_W  = 5,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3,
  parameter int T_GAP  = 2,
  localparam int ROW_W = BANK_W + SUB_W + LOC_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [ROW_W-1:0] reqSrc,
  input logic [ROW_W-1:0] reqDst,
  input logic             busy,
  input logic             cmdValid,
  input logic [1:0]       cmdOp,
  input logic             done,
  input logic             fbValid
);
  localparam int CW = 8;
  logic [CW-1:0] sinceAct, sinceDeact;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct   <= '1;
      sinceDeact <= '1;
    end else begin
      if (cmdValid && cmdOp == 2'd1) sinceAct <= CW'(1);
      else if (sinceAct != '1)       sinceAct <= sinceAct + 1'b1;
      if (cmdValid && cmdOp == 2'd3) sinceDeact <= CW'(1);
      else if (sinceDeact != '1)     sinceDeact <= sinceDeact + 1'b1;
    end
  end

  p_cmd_only_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> busy);
  p_no_cmd_fallback_r8: assert property (@(posedge clk) disable iff (!rstN)
    fbValid |-> !cmdValid);
  p_ras_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == 2'd2 || cmdOp == 2'd3)) |-> sinceAct >= CW'(T_RAS));
  p_gap_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd1) |-> sinceDeact >= CW'(T_GAP));
  p_done_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  p_same_row_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqSrc == reqDst) |=> (done && !cmdValid && !fbValid));
endmodule

bind rowCopySeq rowCopySeq_chk #(
  .BANK_W(BANK_W), .SUB_W(SUB_W), .LOC_W(LOC_W),
  .T_RAS(T_RAS), .T_RP(T_RP), .T_GAP(T_GAP)
) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSrc(reqSrc),
  .reqDst(reqDst), .busy(busy), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .done(done), .fbValid(fbValid)
);

// File: tb/tb_rowCopySeq.sv
module tb_rowCopySeq;
  localparam int BANK_W = 3, SUB_W = 4, LOC_W = 5;
  localparam int T_RAS = 6, T_RP = 3, T_GAP = 2;
  localparam int ROW_W = BANK_W + SUB_W + LOC_W;
  localparam int NBANK = 1 << BANK_W;
  localparam int LW = SUB_W + LOC_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, fbDone = 1'b0;
  logic [ROW_W-1:0] reqSrc = '0, reqDst = '0;
  logic [NBANK-1:0] openMask = '0;
  logic busy, cmdValid, done, fbValid;
  logic [1:0] cmdOp;
  logic [BANK_W-1:0] cmdBank;
  logic [LW-1:0] cmdRow;
  logic [ROW_W-1:0] fbSrc, fbDst;

  int nChecks = 0, nFails = 0, cyc = 0;

  always #5 clk = ~clk;

  rowCopySeq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSrc(reqSrc),
    .reqDst(reqDst), .openMask(openMask), .fbDone(fbDone), .busy(busy),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdRow(cmdRow),
    .done(done), .fbValid(fbValid), .fbSrc(fbSrc), .fbDst(fbDst)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks = nChecks + 1;
    if (!ok) begin
      nFails = nFails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected command code for cycle k of a fast copy (R3..R6)
  function automatic int expOp(input int k, input bit open, output bit useDst);
    int tA, tD, tB, tP;
    tA = open ? 1 + T_RP : 1;
    tD = tA + T_RAS;
    tB = tD + T_GAP;
    tP = tB + T_RAS;
    useDst = (k >= tB);
    if (open && k == 1) return 2;
    if (k == tA || k == tB) return 1;
    if (k == tD) return 3;
    if (k == tP) return 2;
    return 0;
  endfunction

  function automatic int fastDoneAt(input bit open);
    return (open ? 1 + T_RP : 1) + 2 * T_RAS + T_GAP + T_RP;
  endfunction

  task automatic doCopy(input logic [ROW_W-1:0] s, input logic [ROW_W-1:0] d,
                        input bit open, input int fbLat, input bit inject);
    int kind, last, eop;
    bit ud;
    logic [NBANK-1:0] m;
    logic [BANK_W-1:0] bk;
    bk = s[ROW_W-1 -: BANK_W];
    kind = (s == d) ? 0 : (s[ROW_W-1:LOC_W] == d[ROW_W-1:LOC_W]) ? 1 : 2;
    last = (kind == 0) ? 1 : (kind == 1) ? fastDoneAt(open) : fbLat;
    @(negedge clk);
    m = NBANK'($urandom);
    m[bk] = open;
    openMask = m;
    reqSrc = s; reqDst = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    openMask = NBANK'($urandom);
    for (int k = 1; k <= last; k++) begin
      if (inject && k == 2) begin
        reqValid = 1'b1; reqSrc = ~s; reqDst = ~s;
      end else begin
        reqValid = 1'b0;
      end
      fbDone = (kind == 2 && k == fbLat);
      #1;
      eop = (kind == 1) ? expOp(k, open, ud) : 0;
      chk(cmdValid == (eop != 0) && (eop == 0 || cmdOp == eop[1:0]),
          $sformatf("R3 op k=%0d", k), {cmdValid, cmdOp}, eop);
      if (eop != 0) begin
        chk(cmdBank == bk, "R2 bank", cmdBank, bk);
        chk(cmdRow == (ud ? d[LW-1:0] : s[LW-1:0]), "R9 row", cmdRow,
            ud ? d[LW-1:0] : s[LW-1:0]);
      end
      chk(done == (k == last), $sformatf("R7 done k=%0d", k), done, k == last);
      chk(fbValid == (kind == 2), "R8 fbValid", fbValid, kind == 2);
      if (kind == 2)
        chk(fbSrc == s && fbDst == d, "R8 fb addr", fbSrc, s);
      chk(busy, "R9 busy", busy, 1);
      @(negedge clk);
    end
    reqValid = 1'b0;
    fbDone = 1'b0;
    #1;
    chk(!busy && !cmdValid && !done && !fbValid, "R7 idle after done",
        {busy, cmdValid, done, fbValid}, 0);
  endtask

  function automatic logic [ROW_W-1:0] mk(input int b, input int sb, input int r);
    return {BANK_W'(b), SUB_W'(sb), LOC_W'(r)};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !cmdValid && !done && !fbValid, "R1 reset outputs",
        {busy, cmdValid, done, fbValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(!busy && !cmdValid, "R1 idle after reset", {busy, cmdValid}, 0);
    // directed corners
    doCopy(mk(2, 5, 3), mk(2, 5, 3), 1'b0, 0, 1'b0);  // R10 same row
    doCopy(mk(1, 4, 2), mk(1, 4, 17), 1'b0, 0, 1'b0); // R3 R5 R6 closed bank
    doCopy(mk(6, 9, 0), mk(6, 9, 31), 1'b1, 0, 1'b0); // R4 open bank
    doCopy(mk(3, 1, 7), mk(3, 2, 7), 1'b0, 1, 1'b0);  // R8 subarray differs, quick
    doCopy(mk(0, 3, 7), mk(5, 3, 7), 1'b1, 6, 1'b0);  // R8 bank differs, slow
    doCopy(mk(7, 15, 31), mk(7, 15, 0), 1'b1, 0, 1'b1); // R9 inject on fast
    doCopy(mk(4, 0, 1), mk(4, 8, 1), 1'b0, 4, 1'b1);  // R9 inject on fallback
    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      logic [ROW_W-1:0] s, d;
      int sel;
      s = ROW_W'($urandom);
      sel = $urandom_range(0, 9);
      if (sel == 0) d = s;
      else if (sel < 7) d = {s[ROW_W-1:LOC_W], LOC_W'($urandom)};
      else d = ROW_W'($urandom);
      doCopy(s, d, 1'($urandom), $urandom_range(1, 8), 1'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule